// File: doc/BRIEF.md
# System Configuration Register Controller

This block is a small memory-mapped register slice on a plain 32-bit register bus with an address, separate read and write strobes, write data and read data. Its main job is a configuration transaction interface built from three registers: a data word, a command word whose write starts a transaction, and a status word that reports completion and error. Two exact command words are recognised and turned into one-cycle shutdown and reboot request pulses for the platform's power and reset logic. Every other command word completes with an error.

The block also returns a fixed board identifier. It holds a lock register and a reset-control register. A board-variant input (`has_cfg`) selects between two personalities. With the configuration registers present, reset control is reserved: it reads zero and ignores writes. Without them, the configuration offsets behave as unmapped, and reset control stores a write only while the lock register holds the unlock key.

Read data is combinational and is valid in the cycle the read strobe is high. Request pulses and the bad-access flag are registered, so they appear in the cycle after the access.

Top module: `sysreg_cfg_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the data, command and status registers to zero. The shutdown, reboot and bad-access outputs are low after reset.
- R2: The configuration data register at offset 0xA0 stores any written 32-bit value and reads it back unchanged, with no side effect.
- R3: A write to the command register at offset 0xA4 stores the value with bits 19 and 18 forced to zero. A read returns the stored, masked value.
- R4: Every command write replaces the status register (offset 0xA8) with 1 (bit 0 = complete) when the masked word is recognised, and with 3 (bit 1 = error, plus complete) otherwise.
- R5: A masked command word of 0xC0800000 raises `shutdown_req`, and 0xC0900000 raises `reboot_req`, each for exactly the one cycle after the write.
- R6: A direct write to the status register keeps only bits 1:0 of the written value, so software can clear or set complete and error.
- R7: `shutdown_req` and `reboot_req` are never high in the same cycle.
- R8: With `has_cfg` = 1, the reset-control register at offset 0x40 reads as zero and ignores writes.
- R9: With `has_cfg` = 0, reads of offsets 0xA0, 0xA4 and 0xA8 return zero and raise the bad-access flag, and writes there change no register and raise no request pulse.
- R10: With `has_cfg` = 0, a write to reset control is stored only while the lock register (offset 0x20, low 16 bits kept) equals the key 0x5A3C. The lock register reads back its stored value.
- R11: A read of offset 0x00 returns the fixed board identifier parameter (default 0x4D100A01).
- R12: A read of any unmapped offset returns zero and raises `bad_access` for exactly the following cycle. Reads of mapped offsets leave it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| has_cfg | input | 1 | 1 = board variant with the configuration registers |
| addr | input | ADDR_W (12) | Byte offset of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high, zero otherwise |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |
| bad_access | output | 1 | One-cycle flag after a read of an unmapped offset |

## Verification
The command register is driven with the exact shutdown and reboot words, and with a reboot word carrying bits 19:18 set. This shows whether the masking happens before the compare or after it. It is also driven with arbitrary and near-miss words, which must give status 3 and no pulse, and the complete/error status is overwritten both ways to confirm that a command write replaces the old status rather than merging with it. The same offsets are then accessed with the variant input low, and the earlier contents are read back with it high again. This separates register gating from plain read masking. Reset control is tried under both variants, with a wrong key and with the right key.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int OFS_ID     = 'h00;
  localparam int OFS_LOCK   = 'h20;
  localparam int OFS_RSTCTL = 'h40;
  localparam int OFS_CDATA  = 'hA0;
  localparam int OFS_CCTRL  = 'hA4;
  localparam int OFS_CSTAT  = 'hA8;

  localparam logic [31:0] CW_SHUTDOWN = 32'hC080_0000;
  localparam logic [31:0] CW_REBOOT   = 32'hC090_0000;
  localparam logic [31:0] CTRL_DROP   = 32'h000C_0000;

  typedef enum logic [2:0] {
    RG_ID, RG_LOCK, RG_RSTCTL, RG_CDATA, RG_CCTRL, RG_CSTAT, RG_NONE
  } region_e;

  typedef enum logic [1:0] {CMD_NONE, CMD_SHUT, CMD_REBOOT} cmd_e;

  // Command word as it is stored: the two dropped bits are cleared
  function automatic logic [31:0] ctrl_strip(input logic [31:0] w);
    return w & ~CTRL_DROP;
  endfunction

  function automatic cmd_e ctrl_classify(input logic [31:0] masked);
    if (masked == CW_SHUTDOWN) return CMD_SHUT;
    if (masked == CW_REBOOT)   return CMD_REBOOT;
    return CMD_NONE;
  endfunction

  // Status after a command write: bit0 complete, bit1 error
  function automatic logic [1:0] status_after(input cmd_e c);
    return (c == CMD_NONE) ? 2'b11 : 2'b01;
  endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              has_cfg,
  output region_e           region
);

  always_comb begin
    case (addr)
      ADDR_W'(OFS_ID):     region = RG_ID;
      ADDR_W'(OFS_LOCK):   region = RG_LOCK;
      ADDR_W'(OFS_RSTCTL): region = RG_RSTCTL;
      ADDR_W'(OFS_CDATA):  region = has_cfg ? RG_CDATA : RG_NONE;
      ADDR_W'(OFS_CCTRL):  region = has_cfg ? RG_CCTRL : RG_NONE;
      ADDR_W'(OFS_CSTAT):  region = has_cfg ? RG_CSTAT : RG_NONE;
      default:             region = RG_NONE;
    endcase
  end

endmodule

// File: rtl/sysreg_cfg_unit.sv
module sysreg_cfg_unit
  import sysreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  region_e     region,
  input  logic [31:0] wdata,
  output logic [31:0] data_q,
  output logic [31:0] ctrl_q,
  output logic [1:0]  stat_q,
  output logic        shutdown_req,
  output logic        reboot_req,
  output logic        ctrl_wr_evt
);

  logic [31:0] ctrl_masked;
  cmd_e        cmd;
  logic        data_wr_evt;
  logic        stat_wr_evt;

  assign ctrl_wr_evt = wr_en && (region == RG_CCTRL);
  assign data_wr_evt = wr_en && (region == RG_CDATA);
  assign stat_wr_evt = wr_en && (region == RG_CSTAT);
  assign ctrl_masked = ctrl_strip(wdata);
  assign cmd         = ctrl_classify(ctrl_masked);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q       <= '0;
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= ctrl_wr_evt && (cmd == CMD_SHUT);
      reboot_req   <= ctrl_wr_evt && (cmd == CMD_REBOOT);
      if (data_wr_evt) data_q <= wdata;
      if (ctrl_wr_evt) begin
        ctrl_q <= ctrl_masked;
        stat_q <= status_after(cmd);
      end else if (stat_wr_evt) begin
        stat_q <= wdata[1:0];
      end
    end
  end

endmodule

// File: rtl/sysreg_rstctl.sv
module sysreg_rstctl
  import sysreg_pkg::*;
#(
  parameter int               LOCK_W   = 16,
  parameter logic [LOCK_W-1:0] LOCK_KEY = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  region_e           region,
  input  logic              has_cfg,
  input  logic [31:0]       wdata,
  output logic [LOCK_W-1:0] lock_q,
  output logic [31:0]       rstctl_q,
  output logic              lock_ok
);

  assign lock_ok = (lock_q == LOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= '0;
      rstctl_q <= '0;
    end else begin
      if (wr_en && region == RG_LOCK) lock_q <= wdata[LOCK_W-1:0];
      if (wr_en && region == RG_RSTCTL && !has_cfg && lock_ok)
        rstctl_q <= wdata;
    end
  end

endmodule

// File: rtl/sysreg_cfg_ctrl.sv
module sysreg_cfg_ctrl
  import sysreg_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          LOCK_W   = 16,
  parameter logic [31:0] BOARD_ID = 32'h4D10_0A01,
  parameter logic [LOCK_W-1:0] LOCK_KEY = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              has_cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              shutdown_req,
  output logic              reboot_req,
  output logic              bad_access
);

  region_e           region;
  logic [31:0]       data_q;
  logic [31:0]       ctrl_q;
  logic [1:0]        stat_q;
  logic              ctrl_wr_evt;
  logic [LOCK_W-1:0] lock_q;
  logic [31:0]       rstctl_q;
  logic              lock_ok;
  logic [31:0]       rd_mux;

  sysreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .has_cfg (has_cfg),
    .region  (region)
  );

  sysreg_cfg_unit u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .region       (region),
    .wdata        (wdata),
    .data_q       (data_q),
    .ctrl_q       (ctrl_q),
    .stat_q       (stat_q),
    .shutdown_req (shutdown_req),
    .reboot_req   (reboot_req),
    .ctrl_wr_evt  (ctrl_wr_evt)
  );

  sysreg_rstctl #(.LOCK_W(LOCK_W), .LOCK_KEY(LOCK_KEY)) u_rst (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .region   (region),
    .has_cfg  (has_cfg),
    .wdata    (wdata),
    .lock_q   (lock_q),
    .rstctl_q (rstctl_q),
    .lock_ok  (lock_ok)
  );

  always_comb begin
    case (region)
      RG_ID:     rd_mux = BOARD_ID;
      RG_LOCK:   rd_mux = 32'(lock_q);
      RG_RSTCTL: rd_mux = has_cfg ? 32'h0 : rstctl_q;
      RG_CDATA:  rd_mux = data_q;
      RG_CCTRL:  rd_mux = ctrl_q;
      RG_CSTAT:  rd_mux = {30'h0, stat_q};
      default:   rd_mux = 32'h0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : 32'h0;

  always_ff @(posedge clk) begin
    if (rst) bad_access <= 1'b0;
    else     bad_access <= rd_en && (region == RG_NONE);
  end

endmodule

// File: rtl/sysreg_cfg_chk.sv
module sysreg_cfg_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              has_cfg,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              shutdown_req,
  input logic              reboot_req,
  input logic              bad_access,
  input logic [1:0]        stat_q,
  input logic              ctrl_wr_evt
);

  logic [31:0] w_masked;
  logic        cmd_wr;
  logic        cfg_ofs;

  assign w_masked = {wdata[31:20], 2'b00, wdata[17:0]};
  assign cmd_wr   = wr_en && has_cfg && (addr == ADDR_W'('hA4));
  assign cfg_ofs  = (addr == ADDR_W'('hA0)) || (addr == ADDR_W'('hA4)) ||
                    (addr == ADDR_W'('hA8));

  assert_shutdown_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && w_masked == 32'hC080_0000) |=> shutdown_req);

  assert_reboot_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && w_masked == 32'hC090_0000) |=> reboot_req);

  assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shutdown_req, reboot_req}));

  assert_status_complete_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_evt |=> stat_q[0]);

  assert_status_error_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && w_masked != 32'hC080_0000 && w_masked != 32'hC090_0000)
      |=> (stat_q == 2'b11 && !shutdown_req && !reboot_req));

  assert_rstctl_raz_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && has_cfg && addr == ADDR_W'('h40)) |-> (rdata == 32'h0));

  assert_absent_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !has_cfg && cfg_ofs) |-> (rdata == 32'h0));

  assert_absent_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !has_cfg) |=> (!shutdown_req && !reboot_req));

  assert_bad_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !has_cfg && cfg_ofs) |=> bad_access);

endmodule

bind sysreg_cfg_ctrl sysreg_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .has_cfg      (has_cfg),
  .addr         (addr),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .wdata        (wdata),
  .rdata        (rdata),
  .shutdown_req (shutdown_req),
  .reboot_req   (reboot_req),
  .bad_access   (bad_access),
  .stat_q       (stat_q),
  .ctrl_wr_evt  (ctrl_wr_evt)
);

// File: tb/sim_sysreg_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_sysreg_cfg_ctrl;

  localparam int          ADDR_W = 12;
  localparam logic [31:0] ID_VAL = 32'h4D10_0A01;
  localparam logic [15:0] KEY    = 16'h5A3C;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              has_cfg = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              shutdown_req, reboot_req, bad_access;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // scoreboard: expected read values with their requirement tags
  logic [31:0] exp_q[$];
  string       tag_q[$];
  // expected {shutdown, reboot, bad} for the next sample, plus tag
  logic [2:0]  exp_evt = 3'b000;
  string       evt_tag = "R1";

  always #5 clk = ~clk;

  sysreg_cfg_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .has_cfg(has_cfg), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req),
    .bad_access(bad_access)
  );

  // Bench-side model of the register map for bad-access prediction
  function automatic bit is_unmapped(input logic [ADDR_W-1:0] a, input bit v);
    if (a == 'h00 || a == 'h20 || a == 'h40) return 1'b0;
    if (a == 'hA0 || a == 'hA4 || a == 'hA8) return !v;
    return 1'b1;
  endfunction

  function automatic logic [31:0] drop_bits(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    r[19] = 1'b0;
    r[18] = 1'b0;
    return r;
  endfunction

  // Monitor: compares reads and event outputs away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_en) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        tests++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s read addr=%h actual=%h expected=%h", t, addr, rdata, e);
        end
      end
      tests++;
      if ({shutdown_req, reboot_req, bad_access} !== exp_evt) begin
        fails++;
        $display("FAIL %s events actual=%b expected=%b", evt_tag,
                 {shutdown_req, reboot_req, bad_access}, exp_evt);
      end
    end
  end

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input logic [2:0] ev, input string t);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    exp_evt = ev; evt_tag = t;
  endtask

  task automatic do_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                       input string t);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 1'b0;
    exp_evt = {2'b00, is_unmapped(a, has_cfg)};
    evt_tag = is_unmapped(a, has_cfg) ? (has_cfg ? "R12" : "R9") : t;
  endtask

  task automatic idle(input string t);
    @(posedge clk); #1;
    exp_evt = 3'b000; evt_tag = t;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_ctrl;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    do_rd('hA0, 32'h0, "R1");
    do_rd('hA4, 32'h0, "R1");
    do_rd('hA8, 32'h0, "R1");

    // R2: data register round trip
    do_wr('hA0, 32'hDEAD_BEEF, 3'b000, "R2");
    do_rd('hA0, 32'hDEAD_BEEF, "R2");

    // R3/R4: unrecognised word, masked storage, error status
    do_wr('hA4, 32'h1234_5678, 3'b000, "R4");
    do_rd('hA4, drop_bits(32'h1234_5678), "R3");
    do_rd('hA8, 32'h3, "R4");

    // R6: direct status writes keep two bits
    do_wr('hA8, 32'hFFFF_FFFC, 3'b000, "R6");
    do_rd('hA8, 32'h0, "R6");
    do_wr('hA8, 32'h0000_0007, 3'b000, "R6");
    do_rd('hA8, 32'h3, "R6");

    // R5: shutdown pulse, status replaced by complete only (R4)
    do_wr('hA4, 32'hC080_0000, 3'b100, "R5");
    idle("R5");
    do_rd('hA8, 32'h1, "R4");

    // R5/R3: reboot word with dropped bits set still matches
    do_wr('hA4, 32'hC09C_0000, 3'b010, "R5");
    idle("R7");
    do_rd('hA4, 32'hC090_0000, "R3");

    // R4: near miss gives error, no pulse
    last_ctrl = 32'hC0A0_0000;
    do_wr('hA4, last_ctrl, 3'b000, "R4");
    do_rd('hA8, 32'h3, "R4");

    // R8: reset control reserved on this variant
    do_rd('h40, 32'h0, "R8");
    do_wr('h20, 32'(KEY), 3'b000, "R8");
    do_wr('h40, 32'h0000_0155, 3'b000, "R8");
    do_rd('h40, 32'h0, "R8");

    // R11: board identifier
    do_rd('h00, ID_VAL, "R11");

    // R12: unmapped read flags, mapped read does not
    do_rd('h010, 32'h0, "R12");
    do_rd('hA0, 32'hDEAD_BEEF, "R12");
    do_rd('hFFC, 32'h0, "R12");

    // R9: variant without configuration registers
    has_cfg = 1'b0;
    do_rd('hA0, 32'h0, "R9");
    do_rd('hA8, 32'h0, "R9");
    do_wr('hA4, 32'hC080_0000, 3'b000, "R9");
    do_wr('hA0, 32'h1111_2222, 3'b000, "R9");
    do_wr('hA8, 32'h0, 3'b000, "R9");

    // R10: lock-gated reset control
    do_wr('h20, 32'h0000_1111, 3'b000, "R10");
    do_wr('h40, 32'h0000_0077, 3'b000, "R10");
    do_rd('h40, 32'h0, "R10");
    do_wr('h20, 32'hFFFF_0000 | 32'(KEY), 3'b000, "R10");
    do_rd('h20, 32'(KEY), "R10");
    do_wr('h40, 32'h0000_0077, 3'b000, "R10");
    do_rd('h40, 32'h0000_0077, "R10");

    // R9: registers untouched while hidden
    has_cfg = 1'b1;
    do_rd('hA0, 32'hDEAD_BEEF, "R9");
    do_rd('hA4, last_ctrl, "R9");
    do_rd('hA8, 32'h3, "R9");
    do_rd('h40, 32'h0, "R8");

    idle("R1");
    idle("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule